// File: doc/BRIEF.md
# Link-Address Call Stack

This block is a small last-in-first-out store that stands in for general-purpose register x1 of a compact processor core. The core never addresses the stack directly: every instruction that names x1 as a source takes its operand from the top of the stack and removes that entry, and every instruction that names x1 as its destination places the written value on top. A subroutine call that links through x1 therefore saves its return address (the caller supplies the jump address plus 4 as write data), and a return that reads x1 retrieves it and drops it.

Per instruction the core presents a valid strobe, one flag per source operand that names x1, one flag for a destination of x1, and the write data. The top entry is offered combinationally on the read port during that cycle. When one instruction both reads and writes x1, the removal and the insertion merge into a replacement of the top entry, so the occupancy does not change and such an instruction is legal even on a full stack. Illegal accesses raise a one-cycle call-stack error in the same cycle and leave the stack untouched. A synchronous clear empties the stack at the start of every program run.

Occupancy is tracked by a three-state controller. States: `CS_EMPTY` (no entries), `CS_PARTIAL` (between one and DEPTH-1 entries), `CS_FULL` (DEPTH entries). Transitions: fill (`CS_EMPTY` to `CS_PARTIAL` on an insertion), top-out (`CS_PARTIAL` to `CS_FULL` on an insertion at DEPTH-1 entries), drain (`CS_FULL` to `CS_PARTIAL` on a removal), last-out (`CS_PARTIAL` to `CS_EMPTY` on a removal at one entry), and clear (any state to `CS_EMPTY` on the clear input). A replacement, a faulting access and an idle cycle hold the state.

Top module: `link_stack`

## Requirements
- R1: After reset, and in the cycle after clr_i is high, empty_o is 1, full_o is 0 and rdata_o is 0; clr_i overrides any instruction presented in the same cycle and err_o stays 0 in that cycle.
- R2: A valid instruction with dst_i=1 and both source flags 0 on a stack that is not full adds wdata_i on top; from the next cycle rdata_o equals that value and empty_o is 0.
- R3: While the stack holds entries, rdata_o equals the most recently added live entry; a valid instruction with a source flag set and dst_i=0 removes it, after which rdata_o shows the entry below it (0 once empty).
- R4: A valid instruction with src_a_i or src_b_i set while the stack is empty drives err_o to 1 in that same cycle, including when both source flags are set.
- R5: A valid instruction with dst_i=1 and both source flags 0 while the stack is full drives err_o to 1 in that same cycle.
- R6: A valid instruction with a source flag and dst_i set on a non-empty stack raises no error, even when full; the top entry is replaced by wdata_i and empty_o and full_o keep their values.
- R7: In a cycle where err_o is 1, stored entries and occupancy do not change: rdata_o, empty_o and full_o hold their values into the next cycle.
- R8: empty_o is 1 exactly when no entries are held and full_o is 1 exactly when DEPTH entries are held; never both.
- R9: err_o is 0 whenever op_valid_i is 0, whatever the other operand flags are, and the flags have no effect in such a cycle.
- R10: An instruction with both source flags set removes a single entry, the same as one source flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to empty, start of program run |
| op_valid_i | input | 1 | An instruction is presented this cycle |
| src_a_i | input | 1 | First source operand names x1 |
| src_b_i | input | 1 | Second source operand names x1 |
| dst_i | input | 1 | Destination operand names x1 |
| wdata_i | input | WIDTH | Value written to x1 (link address for a call) |
| rdata_o | output | WIDTH | Current top entry, 0 when empty |
| err_o | output | 1 | Call-stack error for the presented instruction |
| empty_o | output | 1 | No entries held |
| full_o | output | 1 | DEPTH entries held |

## Verification
Directed sequences fill the stack entry by entry to full and drain it back to empty, which separates correct ordering from a pointer that is off by one and shows each level transition. Faulting accesses are aimed at both boundaries: a read on empty with one and with both source flags, a plain write on full, and a combined read-write on full, which tells apart an overflow rule that ignores the paired removal from the correct one. Idle cycles with operand flags raised and a clear presented together with a live instruction show that neither leaks into the state. A long pseudo-random mix of inserts, removals, replacements and rare clears is then compared on every cycle against a queue-based model.

// File: rtl/cs_pkg.sv
package cs_pkg;

    // Occupancy level of the stack; drives the empty and full flags.
    typedef enum logic [1:0] {
        CS_EMPTY   = 2'd0,
        CS_PARTIAL = 2'd1,
        CS_FULL    = 2'd2
    } cs_level_e;

    // Action decided for the instruction in the current cycle.
    typedef enum logic [2:0] {
        ACT_IDLE  = 3'd0,
        ACT_PUSH  = 3'd1,
        ACT_POP   = 3'd2,
        ACT_SWAP  = 3'd3,
        ACT_CLEAR = 3'd4,
        ACT_FAULT = 3'd5
    } cs_act_e;

endpackage

// File: rtl/cs_ctrl.sv
module cs_ctrl
    import cs_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      clr_i,
    input  logic      op_valid_i,
    input  logic      src_a_i,
    input  logic      src_b_i,
    input  logic      dst_i,
    input  logic      ptr_one_i,
    input  logic      ptr_below_top_i,
    output cs_act_e   act_o,
    output cs_level_e level_o,
    output logic      err_o
);

    cs_level_e state_q;
    cs_level_e state_d;
    cs_act_e   act;
    logic      rd_x1;
    logic      wr_x1;

    // Two sources naming x1 still mean a single read of the top.
    assign rd_x1 = src_a_i | src_b_i;
    assign wr_x1 = dst_i;

    // Action decode from the instruction and the present level.
    always_comb begin
        act = ACT_IDLE;
        if (clr_i) begin
            act = ACT_CLEAR;
        end else if (op_valid_i) begin
            unique case (state_q)
                CS_EMPTY: begin
                    if (rd_x1)      act = ACT_FAULT;
                    else if (wr_x1) act = ACT_PUSH;
                end
                CS_PARTIAL: begin
                    if (rd_x1 && wr_x1) act = ACT_SWAP;
                    else if (rd_x1)     act = ACT_POP;
                    else if (wr_x1)     act = ACT_PUSH;
                end
                CS_FULL: begin
                    if (rd_x1 && wr_x1) act = ACT_SWAP;
                    else if (rd_x1)     act = ACT_POP;
                    else if (wr_x1)     act = ACT_FAULT;
                end
                default: act = ACT_FAULT;
            endcase
        end
    end

    // Next-state logic: fill, top-out, drain, last-out, clear.
    always_comb begin
        state_d = state_q;
        if (act == ACT_CLEAR) begin
            state_d = CS_EMPTY;
        end else begin
            unique case (state_q)
                CS_EMPTY: begin
                    if (act == ACT_PUSH) state_d = CS_PARTIAL;
                end
                CS_PARTIAL: begin
                    if (act == ACT_PUSH && ptr_below_top_i)   state_d = CS_FULL;
                    else if (act == ACT_POP && ptr_one_i)     state_d = CS_EMPTY;
                end
                CS_FULL: begin
                    if (act == ACT_POP) state_d = CS_PARTIAL;
                end
                default: state_d = CS_EMPTY;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CS_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        act_o   = act;
        level_o = state_q;
        err_o   = (act == ACT_FAULT);
    end

endmodule

// File: rtl/cs_ptr.sv
module cs_ptr
    import cs_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  cs_act_e          act_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             one_o,
    output logic             below_top_o
);

    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
    localparam logic [PTR_W-1:0] PTR_BELOW_TOP = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;

    // Count of live entries; a replacement leaves it alone.
    always_comb begin
        ptr_d = ptr_q;
        unique case (act_i)
            ACT_CLEAR: ptr_d = '0;
            ACT_PUSH:  ptr_d = ptr_q + PTR_ONE;
            ACT_POP:   ptr_d = ptr_q - PTR_ONE;
            default:   ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr_o       = ptr_q;
    assign one_o       = (ptr_q == PTR_ONE);
    assign below_top_o = (ptr_q == PTR_BELOW_TOP);

endmodule

// File: rtl/cs_mem.sv
module cs_mem
    import cs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  cs_act_e          act_i,
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] top_o
);

    logic [WIDTH-1:0] ent_q [DEPTH];

    // One register per slot; slot k is written by an insertion when k
    // entries are held, or by a replacement when k+1 entries are held.
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        logic wr_en;
        assign wr_en = ((act_i == ACT_PUSH) && (ptr_i == PTR_W'(k))) ||
                       ((act_i == ACT_SWAP) && (ptr_i == PTR_W'(k + 1)));

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                ent_q[k] <= '0;
            end else if (wr_en) begin
                ent_q[k] <= wdata_i;
            end
        end
    end

    // Top-of-stack read; zero when nothing is held.
    always_comb begin
        top_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (ptr_i == PTR_W'(k + 1)) begin
                top_o = ent_q[k];
            end
        end
    end

endmodule

// File: rtl/link_stack.sv
module link_stack
    import cs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             op_valid_i,
    input  logic             src_a_i,
    input  logic             src_b_i,
    input  logic             dst_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             err_o,
    output logic             empty_o,
    output logic             full_o
);

    localparam int PTR_W = $clog2(DEPTH + 1);

    cs_act_e          act;
    cs_level_e        level;
    logic [PTR_W-1:0] ptr;
    logic             ptr_one;
    logic             ptr_below_top;

    cs_ctrl u_ctrl (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .clr_i           (clr_i),
        .op_valid_i      (op_valid_i),
        .src_a_i         (src_a_i),
        .src_b_i         (src_b_i),
        .dst_i           (dst_i),
        .ptr_one_i       (ptr_one),
        .ptr_below_top_i (ptr_below_top),
        .act_o           (act),
        .level_o         (level),
        .err_o           (err_o)
    );

    cs_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .act_i       (act),
        .ptr_o       (ptr),
        .one_o       (ptr_one),
        .below_top_o (ptr_below_top)
    );

    cs_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .act_i   (act),
        .ptr_i   (ptr),
        .wdata_i (wdata_i),
        .top_o   (rdata_o)
    );

    assign empty_o = (level == CS_EMPTY);
    assign full_o  = (level == CS_FULL);

endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             clr_i,
    input logic             op_valid_i,
    input logic             src_a_i,
    input logic             src_b_i,
    input logic             dst_i,
    input logic [WIDTH-1:0] wdata_i,
    input logic [WIDTH-1:0] rdata_o,
    input logic             err_o,
    input logic             empty_o,
    input logic             full_o
);

    logic live;
    logic rd;
    assign live = op_valid_i && !clr_i;
    assign rd   = src_a_i || src_b_i;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (empty_o && !full_o && rdata_o == '0)); // R1
    AST_CLEAR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |-> !err_o); // R1
    AST_PUSH_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && dst_i && !rd && !err_o) |=> (rdata_o == $past(wdata_i) && !empty_o)); // R2
    AST_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && rd && empty_o) |-> err_o); // R4
    AST_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && dst_i && !rd && full_o) |-> err_o); // R5
    AST_SWAP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && rd && dst_i && !empty_o) |-> !err_o); // R6
    AST_SWAP_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && rd && dst_i && !empty_o) |=>
        (rdata_o == $past(wdata_i) && $stable(empty_o) && $stable(full_o))); // R6
    AST_ERR_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o && !clr_i) |=> ($stable(rdata_o) && $stable(empty_o) && $stable(full_o))); // R7
    AST_LEVEL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(empty_o && full_o)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !op_valid_i |-> !err_o); // R9

endmodule

bind link_stack cs_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_cs_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .op_valid_i (op_valid_i),
    .src_a_i    (src_a_i),
    .src_b_i    (src_b_i),
    .dst_i      (dst_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .err_o      (err_o),
    .empty_o    (empty_o),
    .full_o     (full_o)
);

// File: tb/link_stack_bench.sv
module link_stack_bench;

    localparam int DEPTH = 8;
    localparam int WIDTH = 32;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             clr_i = 1'b0;
    logic             op_valid_i = 1'b0;
    logic             src_a_i = 1'b0;
    logic             src_b_i = 1'b0;
    logic             dst_i = 1'b0;
    logic [WIDTH-1:0] wdata_i = '0;
    logic [WIDTH-1:0] rdata_o;
    logic             err_o;
    logic             empty_o;
    logic             full_o;

    int vectors = 0;
    int miscompares = 0;
    logic [WIDTH-1:0] model [$];
    logic [31:0] rs = 32'h1234_5679;

    always #4 clk_i = ~clk_i;

    link_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_link_stack (
        .clk_i, .rst_ni, .clr_i, .op_valid_i, .src_a_i, .src_b_i,
        .dst_i, .wdata_i, .rdata_o, .err_o, .empty_o, .full_o
    );

    task automatic cmp(input string tag, input string what, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Apply one instruction, compare all outputs, then advance the model.
    task automatic step(input logic v, input logic a, input logic b, input logic d,
                        input logic [WIDTH-1:0] wd, input logic c, input string tag);
        logic rd;
        logic exp_err;
        @(negedge clk_i);
        op_valid_i = v; src_a_i = a; src_b_i = b; dst_i = d; wdata_i = wd; clr_i = c;
        #1;
        rd = a | b;
        exp_err = v && !c && ((rd && model.size() == 0) ||
                              (d && !rd && model.size() == DEPTH));
        vectors++;
        cmp(tag, "err_o", {31'd0, err_o}, {31'd0, exp_err});
        cmp(tag, "rdata_o", rdata_o, (model.size() == 0) ? '0 : model[$]);
        cmp(tag, "empty_o", {31'd0, empty_o}, {31'd0, model.size() == 0});
        cmp(tag, "full_o", {31'd0, full_o}, {31'd0, model.size() == DEPTH});
        if (c) begin
            model.delete();
        end else if (v && !exp_err) begin
            if (rd && d)   model[model.size() - 1] = wd;
            else if (rd)   void'(model.pop_back());
            else if (d)    model.push_back(wd);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        miscompares++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
        step(0, 0, 0, 0, '0, 0, "R1 reset state");
        // Fill with call addresses.
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 32'h100 + 4 * i, 0, "R2 push");
        step(1, 1, 0, 0, '0, 0, "R3 pop");
        step(1, 0, 1, 0, '0, 0, "R3 pop second source");
        step(1, 1, 0, 0, '0, 0, "R3 pop last");
        step(1, 1, 0, 0, '0, 0, "R4 underflow");
        step(1, 1, 1, 0, '0, 0, "R4 underflow both sources");
        step(1, 1, 1, 1, 32'hdead, 0, "R4 read-write on empty");
        step(0, 1, 1, 1, 32'hbeef, 0, "R9 idle with flags");
        step(0, 0, 0, 0, '0, 0, "R9 idle shows no change");
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 1, 32'h2000 + i, 0, "R8 fill to full");
        step(1, 0, 0, 1, 32'h5555, 0, "R5 overflow");
        step(0, 0, 0, 0, '0, 0, "R7 frozen after fault");
        step(1, 1, 0, 1, 32'h7777, 0, "R6 replace on full");
        step(1, 0, 0, 0, '0, 0, "R6 replaced top");
        step(1, 1, 1, 0, '0, 0, "R10 both sources one pop");
        step(1, 0, 0, 0, '0, 0, "R10 next entry");
        step(1, 0, 0, 1, 32'h9999, 1, "R1 clear beats push");
        step(0, 0, 0, 0, '0, 0, "R1 cleared");
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] r;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            r = rs;
            step(r[0] | r[1], r[2] & r[3], r[4] & r[5] & r[6], r[7] | r[8] & r[9],
                 {r[31:10], 10'h0}, (r[15:10] == 6'd0), "R8 random mix");
        end
        finish_run();
    end

endmodule